// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The controller gathers interrupt request lines from a set of devices and presents one interrupt request and one source index to the processor. Every request is caught in a pending bit, so a request that arrives while interrupts are masked or while a handler is running is held and not lost. Among the pending sources a fixed priority picks one winner: line 0 is the most urgent and line `NUM_LINES-1` the least. The processor only accepts an interrupt on an instruction-boundary strobe. When it accepts, the controller pulses an acknowledge to the chosen device, so the device can drop its line, and records the source as in service.

The in-service record is a stack of priority levels. The top of the stack is the current level, and an end-of-interrupt strobe pops it. In nesting mode a pending source is forwarded only if it is strictly more urgent than the current level, so an urgent device can preempt a running handler of lower priority. In sequential mode nothing is forwarded while any handler is in service. After each pop the controller checks the pending bits again.

The control flow uses three states. `S_IDLE` means nothing is in service. `S_ACTIVE` means at least one handler is in service. `S_ACK` is the single cycle in which the acknowledge is driven. The transitions are: take (`S_IDLE`/`S_ACTIVE` to `S_ACK`), settle (`S_ACK` to `S_ACTIVE`), and last pop (`S_ACTIVE` to `S_IDLE`, when the end-of-interrupt strobe empties the stack).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `cpu_irq` is 0, `cpu_vec` is 0, `dev_ack` is 0, and no source is pending or in service.
- R2: A line that is high at a clock edge sets its pending bit, and that bit stays set until the source is taken, even if the line drops first. A newly pending source can raise `cpu_irq` in the cycle after the edge that captured it.
- R3: `cpu_irq` is 1 exactly when `int_en` is 1, the block is not in its acknowledge cycle, and an eligible pending source exists. `cpu_vec` then gives the lowest-numbered eligible source, and it is 0 whenever `cpu_irq` is 0.
- R4: A take happens at a clock edge where `cpu_irq`, `insn_boundary` and not `eoi` all hold. In the next cycle `dev_ack` has exactly the bit of the taken source set, for one cycle only, and `cpu_irq` is 0 in that cycle.
- R5: Without `insn_boundary`, no take happens: `dev_ack` stays 0 and the pending source stays requested.
- R6: While `int_en` is 0, `cpu_irq` is 0 and no take happens, but pending bits are kept.
- R7: With `nest_en` = 1 and a handler in service, a pending source is eligible only if its line number is strictly lower than the lowest in-service line number.
- R8: With `nest_en` = 0, no source is eligible while any source is in service.
- R9: `eoi` removes the lowest-numbered in-service source, after which pending sources are evaluated again. `eoi` has no effect in the acknowledge cycle or when nothing is in service, and a high `eoi` at an edge blocks a take at that edge.
- R10: A line that is still high during its own acknowledge cycle does not set its pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Device request lines, bit i from device i |
| int_en | input | 1 | Global interrupt enable |
| nest_en | input | 1 | 1 = priority nesting, 0 = sequential handling |
| insn_boundary | input | 1 | Processor is at an instruction boundary |
| eoi | input | 1 | End of the current handler |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | IDX_W | Index of the winning source |
| dev_ack | output | NUM_LINES | One-cycle acknowledge, one bit per device |

## Verification
The hardest situation to reach from the ports is a stack several levels deep in which a less urgent source waits behind two nested handlers. It must surface only after the second pop, and an `eoi` that lands in an acknowledge cycle must be ignored. Directed steps build this by raising a mid-priority line, taking it, then raising a more urgent line with the boundary strobe held low for some cycles before taking it. The bench then issues pops one at a time and checks the request after each one. A long random phase follows, with lines, strobes, the enable and the mode all changing, and a behavioural queue model is compared against the outputs on every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_ACK    = 2'd2
    } irq_state_e;
endpackage

// File: rtl/prio_irq_lowest.sv
module prio_irq_lowest #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_pending.sv
module prio_irq_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] ack_live,
    input  logic [N-1:0] take_mask,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | (lines & ~ack_live)) & ~take_mask;
    end
endmodule

// File: rtl/prio_irq_inservice.sv
module prio_irq_inservice #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  push_mask,
    input  logic          pop,
    output logic          any,
    output logic          last,
    output logic [IW-1:0] level
);
    logic [N-1:0] act_q;

    // Nesting only pushes more urgent levels, so the stack top is the lowest set bit.
    always_ff @(posedge clk) begin
        if (!rst_n)   act_q <= '0;
        else if (pop) act_q <= act_q & (act_q - N'(1));
        else          act_q <= act_q | push_mask;
    end

    assign last = $onehot(act_q);

    prio_irq_lowest #(.N(N), .IW(IW)) u_top (
        .req   (act_q),
        .found (any),
        .idx   (level)
    );
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 int_en,
    input  logic                 nest_en,
    input  logic                 insn_boundary,
    input  logic                 eoi,
    output logic                 cpu_irq,
    output logic [IDX_W-1:0]     cpu_vec,
    output logic [NUM_LINES-1:0] dev_ack
);
    irq_state_e             state_q, state_d;
    logic [NUM_LINES-1:0]   pend_q, elig, take_mask, ack_q;
    logic                   is_any, is_last, elig_any, take, pop;
    logic [IDX_W-1:0]       cur_lvl, win_idx;

    prio_irq_pending #(.N(NUM_LINES)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (irq_lines),
        .ack_live  (dev_ack),
        .take_mask (take_mask),
        .pend      (pend_q)
    );

    prio_irq_inservice #(.N(NUM_LINES), .IW(IDX_W)) u_isr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_mask (take_mask),
        .pop       (pop),
        .any       (is_any),
        .last      (is_last),
        .level     (cur_lvl)
    );

    // Eligibility per line: nothing in service, or nesting and strictly more urgent.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
        assign elig[g] = pend_q[g] & (~is_any | (nest_en & (IDX_W'(g) < cur_lvl)));
    end

    prio_irq_lowest #(.N(NUM_LINES), .IW(IDX_W)) u_win (
        .req   (elig),
        .found (elig_any),
        .idx   (win_idx)
    );

    assign take      = cpu_irq & insn_boundary & ~eoi;
    assign pop       = eoi & is_any & (state_q != S_ACK);
    assign take_mask = take ? (NUM_LINES'(1) << win_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)    ack_q <= '0;
        else if (take) ack_q <= take_mask;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (take) state_d = S_ACK;
            S_ACTIVE: begin
                if (take)                 state_d = S_ACK;
                else if (pop && is_last)  state_d = S_IDLE;
            end
            S_ACK:    state_d = S_ACTIVE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_irq = 1'b0;
        cpu_vec = '0;
        dev_ack = '0;
        unique case (state_q)
            S_IDLE, S_ACTIVE: begin
                cpu_irq = int_en & elig_any;
                cpu_vec = cpu_irq ? win_idx : '0;
            end
            S_ACK:   dev_ack = ack_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 int_en,
    input logic                 insn_boundary,
    input logic                 eoi,
    input logic                 cpu_irq,
    input logic [IDX_W-1:0]     cpu_vec,
    input logic [NUM_LINES-1:0] dev_ack
);
    assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));

    assert_ack_follows_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && insn_boundary && !eoi) |=> (dev_ack == (NUM_LINES'(1) << $past(cpu_vec))));

    assert_ack_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |=> (dev_ack == '0));

    assert_no_irq_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |-> !cpu_irq);

    assert_vec_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_irq |-> (cpu_vec == '0));

    assert_no_take_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_irq && insn_boundary) |=> (dev_ack == '0));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !cpu_irq);

    assert_eoi_blocks_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> (dev_ack == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_en        (int_en),
    .insn_boundary (insn_boundary),
    .eoi           (eoi),
    .cpu_irq       (cpu_irq),
    .cpu_vec       (cpu_vec),
    .dev_ack       (dev_ack)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_lines;
    logic          int_en, nest_en, insn_boundary, eoi;
    logic          cpu_irq;
    logic [IW-1:0] cpu_vec;
    logic [N-1:0]  dev_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_LINES(N)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_en(int_en),
        .nest_en(nest_en), .insn_boundary(insn_boundary), .eoi(eoi),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .dev_ack(dev_ack)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: pending set, queue of in-service levels, ack flag.
    bit [N-1:0] m_pend;
    int         m_stk[$];
    bit         m_in_ack;
    int         m_ack;

    function automatic int m_winner();
        if (!int_en || m_in_ack) return -1;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i]) begin
                if (m_stk.size() == 0) return i;
                if (nest_en && i < m_stk[m_stk.size()-1]) return i;
                return -1;
            end
        end
        return -1;
    endfunction

    always @(posedge clk) begin : model
        int w;
        bit tk, pp;
        if (!rst_n) begin
            m_pend = '0; m_stk.delete(); m_in_ack = 0; m_ack = -1;
        end else begin
            w  = m_winner();
            tk = (w >= 0) && insn_boundary && !eoi;
            pp = eoi && !m_in_ack && (m_stk.size() > 0);
            for (int i = 0; i < N; i++)
                if (irq_lines[i] && !(m_in_ack && m_ack == i)) m_pend[i] = 1'b1;
            if (tk) begin
                m_pend[w] = 1'b0;
                m_stk.push_back(w);
            end
            if (pp) void'(m_stk.pop_back());
            m_in_ack = tk;
            m_ack    = tk ? w : -1;
        end
    end

    initial begin : compare
        int w;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                w = m_winner();
                check("R3 cpu_irq vs model", int'(cpu_irq), int'(w >= 0));
                check("R3 cpu_vec vs model", int'(cpu_vec), (w >= 0) ? w : 0);
                check("R4 dev_ack vs model", int'(dev_ack), m_in_ack ? (1 << m_ack) : 0);
            end
        end
    end

    // Device behaviour: a line stays up until acknowledged unless keep is set.
    task automatic drive(input logic [N-1:0] raise, input logic [N-1:0] drop,
                         input logic bnd, input logic e, input bit keep = 0);
        @(negedge clk);
        irq_lines     = ((irq_lines | raise) & ~drop) & (keep ? {N{1'b1}} : ~dev_ack);
        insn_boundary = bnd;
        eoi           = e;
        @(posedge clk);
        #3;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 0; irq_lines = '0; int_en = 0; nest_en = 1; insn_boundary = 0; eoi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #3;
        check("R1 cpu_irq after reset", int'(cpu_irq), 0);
        check("R1 cpu_vec after reset", int'(cpu_vec), 0);
        check("R1 dev_ack after reset", int'(dev_ack), 0);

        // Masked requests stay pending
        drive(8'h28, 0, 0, 0);
        check("R6 masked cpu_irq", int'(cpu_irq), 0);
        drive(0, 8'h28, 0, 0);
        check("R6 masked after drop", int'(cpu_irq), 0);
        drive(0, 0, 1, 0);
        check("R6 no take while masked", int'(dev_ack), 0);
        int_en = 1;
        drive(0, 0, 0, 0);
        check("R2 held request surfaces", int'(cpu_irq), 1);
        check("R3 lowest index wins", int'(cpu_vec), 3);

        // Take 3, then nest 1 above it
        drive(0, 0, 1, 0);
        check("R4 ack for line 3", int'(dev_ack), 8'h08);
        check("R4 no irq in ack cycle", int'(cpu_irq), 0);
        drive(0, 0, 0, 0);
        check("R4 ack is one cycle", int'(dev_ack), 0);
        check("R7 less urgent 5 waits", int'(cpu_irq), 0);
        drive(8'h02, 0, 0, 0);
        check("R7 urgent 1 preempts", int'(cpu_irq), 1);
        check("R7 vec 1", int'(cpu_vec), 1);
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 0, 0);
            check("R5 no ack without boundary", int'(dev_ack), 0);
            check("R5 request held", int'(cpu_irq), 1);
        end
        drive(0, 0, 1, 0);
        check("R7 ack for nested line 1", int'(dev_ack), 8'h02);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 1);
        check("R9 pop to level 3, 5 still waits", int'(cpu_irq), 0);
        drive(0, 0, 0, 1);
        check("R9 recheck after last pop", int'(cpu_irq), 1);
        check("R9 vec 5", int'(cpu_vec), 5);
        drive(0, 0, 1, 0);
        check("R4 ack for line 5", int'(dev_ack), 8'h20);
        drive(0, 0, 0, 1);           // eoi in ack cycle: ignored
        drive(8'h80, 0, 0, 0);
        check("R9 eoi in ack ignored, 7 waits", int'(cpu_irq), 0);
        drive(0, 0, 0, 1);
        check("R9 pop frees 7", int'(cpu_irq), 1);
        check("R9 vec 7", int'(cpu_vec), 7);
        drive(0, 0, 1, 1);
        check("R9 eoi blocks take", int'(dev_ack), 0);
        drive(0, 0, 1, 0);
        check("R4 ack for line 7", int'(dev_ack), 8'h80);
        drive(0, 0, 0, 1);
        drive(0, 0, 0, 1);
        check("R9 stack empty", int'(cpu_irq), 0);

        // Line held through its own ack cycle
        drive(8'h04, 0, 0, 0);
        check("R3 vec 2", int'(cpu_vec), 2);
        drive(0, 0, 1, 0);
        check("R4 ack for line 2", int'(dev_ack), 8'h04);
        drive(0, 0, 0, 0, 1);
        drive(0, 8'h04, 0, 1);
        check("R10 no re-pend from ack cycle", int'(cpu_irq), 0);

        // Sequential mode
        nest_en = 0;
        drive(8'h40, 0, 0, 0);
        check("R3 vec 6", int'(cpu_vec), 6);
        drive(0, 0, 1, 0);
        check("R4 ack for line 6", int'(dev_ack), 8'h40);
        drive(8'h01, 0, 0, 0);
        check("R8 no preempt in sequential", int'(cpu_irq), 0);
        drive(0, 0, 0, 0);
        check("R8 still held", int'(cpu_irq), 0);
        drive(0, 0, 0, 1);
        check("R8 served after pop", int'(cpu_irq), 1);
        check("R8 vec 0", int'(cpu_vec), 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 1);
        drive(0, 0, 0, 1);
        check("R9 eoi on empty stack", int'(cpu_irq), 0);
        check("R9 eoi on empty no ack", int'(dev_ack), 0);
        nest_en = 1;

        // Random phase checked against the model every cycle
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] r, d;
            r = ($urandom % 3 == 0) ? (N'(1) << ($urandom % N)) : '0;
            d = ($urandom % 10 == 0) ? (N'(1) << ($urandom % N)) : '0;
            if (k % 500 == 0) nest_en = ~nest_en;
            int_en = ($urandom % 12 != 0);
            drive(r, d, ($urandom % 3 == 0), ($urandom % 5 == 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule